// File: doc/BRIEF.md
# Multi-Port Open-Drain Bus Hub Repeater

This block is a digital model of a five-port hub for a two-wire open-drain bus. Every port carries a data and a clock signal. When a device pulls a signal low on one active port, the hub pulls the same signal low on every other active port of the hub. A device can still win or lose arbitration and stretch the clock across the hub. The data and clock signals each get their own copy of the logic, and the two copies never interact.

Each pad is reported to the hub as one of three levels: released, a weak low that a hub is driving, or a strong low from an outside device. The weak level lets the hub tell its own echo apart from a real source of low, so it cannot hold itself low. Each signal also has two shared expansion lines, and several hubs wire-AND these lines to form one cluster. The first line says "some hub is repeating a low". The second says "some port in the cluster is still held strongly low". Release follows a fixed order. The port that was held by a device stays weakly low until the whole cluster has let go. That port is then released. The first line rises when the port reads high or a rise timeout ends. The other ports are released last.

Top module: `bus_hub_repeater`

## Requirements
- R1: Port 0 is always active. Ports 1 to 4 are active only while their bit of `enIn` is 1 (bit k-1 enables port k).
- R2: A strong low (pad code 2'b11) on an active port makes the hub pull expansion level-1 low (drive bit 0 = 1). The hub then pulls every active port of its own low (drive bit = 1).
- R3: Expansion level-2 is pulled low (drive bit 1 = 1) while any active port of the hub reads a strong low.
- R4: A port that reads only the weak code 2'b01 is never taken as a source. The hub returns to rest with no drive even while such a port keeps reading weak.
- R5: A port that was a source stays driven low by the hub after its device lets go, for as long as level-2 (input bit 1) reads low.
- R6: Level-1 is released only after level-2 reads high and one of two things has happened: every source port reads released (2'b00), or RISE_CYCLES clocks (1 µs at the default clock) have passed.
- R7: Non-source ports are released only after both expansion inputs read high (2'b11).
- R8: An expansion input pulled low by another hub makes this hub drive all of its active ports low, just as if the low came from a local port.
- R9: A strong low that a device applies to a port the hub is already holding weakly low is repeated. This keeps the cluster low after the first source lets go, which carries clock stretching and arbitration across the hub.
- R10: A disabled port is never driven, and a strong low on it has no effect.
- R11: The data and clock lanes are independent. Activity on one lane leaves the drive and expansion outputs of the other unchanged.
- R12: After reset the hub drives no port and no expansion line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enIn | input | 4 | Enables for ports 1..4 (bit k-1 for port k) |
| sdaPad | input | 10 | Data pad level per port, 2 bits each: 00 released, 01 weak low, 11 strong low |
| sclPad | input | 10 | Clock pad level per port, same coding |
| sdaExpIn | input | 2 | Wired data expansion lines, bit 0 level-1, bit 1 level-2, 1 = high |
| sclExpIn | input | 2 | Wired clock expansion lines, same coding |
| sdaDrive | output | 5 | 1 = hub pulls that port's data pad low |
| sclDrive | output | 5 | 1 = hub pulls that port's clock pad low |
| sdaExpDrive | output | 2 | 1 = hub pulls that data expansion line low |
| sclExpDrive | output | 2 | 1 = hub pulls that clock expansion line low |

## Verification
The assertions assume four things about the inputs. Enables change only while the cluster is idle. Every low lasts longer than the synchroniser depth. Pad codes come from the wired combination of device drive and hub drive. The expansion inputs are the AND of all the hubs' expansion outputs. The bench keeps to these limits by holding each stimulus for tens of cycles and changing enables only after the cluster has returned to rest. It also models two hubs whose pads and expansion nets are built from the outputs of both hubs, and it uses a slow-rising node to force the timeout path.

// File: rtl/hub_pkg.sv
package hub_pkg;

  localparam logic [1:0] PAD_REL    = 2'b00;
  localparam logic [1:0] PAD_WEAK   = 2'b01;
  localparam logic [1:0] PAD_STRONG = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC,
    ST_WAITX2,
    ST_RISE,
    ST_HOLD,
    ST_FOLLOW
  } laneState_e;

  // control -> datapath
  typedef struct packed {
    logic exp1Drv;
    logic driveAll;
    logic driveNonSrc;
    logic captureSrc;
    logic clearSrc;
    logic timerRun;
  } laneStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic anyStrong;
    logic srcAllHigh;
    logic timerDone;
    logic exp1High;
    logic exp2High;
  } laneStatus_t;

endpackage

// File: rtl/hub_sync.sv
module hub_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [STAGES-1:0][WIDTH-1:0] chainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ <= {STAGES{RST_VAL}};
    end else begin
      chainQ[0] <= dIn;
      for (int s = 1; s < STAGES; s++) begin
        chainQ[s] <= chainQ[s-1];
      end
    end
  end

  assign qOut = chainQ[STAGES-1];

endmodule

// File: rtl/hub_lane_dp.sv
module hub_lane_dp
  import hub_pkg::*;
#(
  parameter int NUM_PORTS   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int RISE_CYCLES = 125
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_PORTS-1:0]     portEn,
  input  logic [2*NUM_PORTS-1:0]   padIn,
  input  logic [1:0]               expIn,
  input  laneStrobe_t              strobe,
  output laneStatus_t              status,
  output logic [NUM_PORTS-1:0]     driveLow,
  output logic [1:0]               expDrive
);

  localparam int PAD_W = 2 * NUM_PORTS;
  localparam int TW    = $clog2(RISE_CYCLES + 1);
  localparam logic [TW-1:0] TIMER_LAST = TW'(RISE_CYCLES - 1);

  logic [PAD_W-1:0]     padS;
  logic [1:0]           expS;
  logic [NUM_PORTS-1:0] strongVec;
  logic [NUM_PORTS-1:0] highVec;
  logic [NUM_PORTS-1:0] srcMaskQ;
  logic [TW-1:0]        timerQ;
  logic                 exp2DrvQ;
  logic                 timerDone;

  hub_sync #(.WIDTH(PAD_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_padSync (
    .clk (clk),
    .rstN(rstN),
    .dIn (padIn),
    .qOut(padS)
  );

  hub_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_expSync (
    .clk (clk),
    .rstN(rstN),
    .dIn (expIn),
    .qOut(expS)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign strongVec[p] = portEn[p] && (padS[2*p +: 2] == PAD_STRONG);
    assign highVec[p]   = (padS[2*p +: 2] == PAD_REL);
    assign driveLow[p]  = portEn[p] &
                          (strobe.driveAll | (strobe.driveNonSrc & ~srcMaskQ[p]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcMaskQ <= '0;
    end else if (strobe.clearSrc) begin
      srcMaskQ <= '0;
    end else if (strobe.captureSrc) begin
      srcMaskQ <= srcMaskQ | strongVec;
    end
  end

  assign timerDone = (timerQ == TIMER_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerQ <= '0;
    end else if (!strobe.timerRun) begin
      timerQ <= '0;
    end else if (!timerDone) begin
      timerQ <= timerQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) exp2DrvQ <= 1'b0;
    else       exp2DrvQ <= |strongVec;
  end

  assign expDrive          = {exp2DrvQ, strobe.exp1Drv};
  assign status.anyStrong  = |strongVec;
  assign status.srcAllHigh = &(highVec | ~(srcMaskQ & portEn));
  assign status.timerDone  = timerDone;
  assign status.exp1High   = expS[0];
  assign status.exp2High   = expS[1];

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    timerQ <= TIMER_LAST); // R6

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    AST_SRC_HELD: assert property (@(posedge clk) disable iff (!rstN)
      ($fell(driveLow[p]) && srcMaskQ[p]) |-> status.exp2High); // R5
  end

endmodule

// File: rtl/hub_lane_ctrl.sv
module hub_lane_ctrl
  import hub_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  laneStatus_t sts,
  output laneStrobe_t str
);

  laneState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    if (sts.anyStrong) begin
      stateD = ST_SRC;
    end else begin
      unique case (stateQ)
        ST_IDLE:   if (!sts.exp1High || !sts.exp2High) stateD = ST_FOLLOW;
        ST_SRC:    stateD = ST_WAITX2;
        ST_WAITX2: if (sts.exp2High) stateD = ST_RISE;
        ST_RISE: begin
          if (!sts.exp2High)                           stateD = ST_WAITX2;
          else if (sts.srcAllHigh || sts.timerDone)    stateD = ST_HOLD;
        end
        ST_HOLD:   if (sts.exp1High && sts.exp2High) stateD = ST_IDLE;
        ST_FOLLOW: if (sts.exp1High && sts.exp2High) stateD = ST_IDLE;
        default:   stateD = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    str            = '0;
    str.captureSrc = (stateQ != ST_IDLE);
    str.clearSrc   = (stateQ == ST_IDLE);
    unique case (stateQ)
      ST_SRC, ST_WAITX2: begin
        str.exp1Drv  = 1'b1;
        str.driveAll = 1'b1;
      end
      ST_RISE: begin
        str.exp1Drv     = 1'b1;
        str.driveNonSrc = 1'b1;
        str.timerRun    = 1'b1;
      end
      ST_HOLD:   str.driveNonSrc = 1'b1;
      ST_FOLLOW: str.driveAll    = 1'b1;
      default: ;
    endcase
  end

  AST_SRC_RAISES_EXP1: assert property (@(posedge clk) disable iff (!rstN)
    sts.anyStrong |=> str.exp1Drv); // R2

  AST_EXP1_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    $fell(str.exp1Drv) |-> $past(sts.exp2High && (sts.srcAllHigh || sts.timerDone))); // R6

  AST_IDLE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IDLE && $past(stateQ) != ST_IDLE) |-> $past(sts.exp1High && sts.exp2High)); // R7

  AST_FOLLOW_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    (!sts.exp1High && !sts.anyStrong && stateQ == ST_IDLE) |=> str.driveAll); // R8

endmodule

// File: rtl/bus_hub_repeater.sv
module bus_hub_repeater
  import hub_pkg::*;
#(
  parameter int NUM_PORTS   = 5,
  parameter int SYNC_STAGES = 2,
  parameter int CLK_MHZ     = 125,
  parameter int RISE_NS     = 1000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_PORTS-2:0]   enIn,
  input  logic [2*NUM_PORTS-1:0] sdaPad,
  input  logic [2*NUM_PORTS-1:0] sclPad,
  input  logic [1:0]             sdaExpIn,
  input  logic [1:0]             sclExpIn,
  output logic [NUM_PORTS-1:0]   sdaDrive,
  output logic [NUM_PORTS-1:0]   sclDrive,
  output logic [1:0]             sdaExpDrive,
  output logic [1:0]             sclExpDrive
);

  localparam int RISE_RAW    = (CLK_MHZ * RISE_NS) / 1000;
  localparam int RISE_CYCLES = (RISE_RAW < 1) ? 1 : RISE_RAW;
  localparam int NUM_LANES   = 2;

  logic [NUM_PORTS-1:0] portEn;
  assign portEn = {enIn, 1'b1};

  logic [NUM_LANES-1:0][2*NUM_PORTS-1:0] padL;
  logic [NUM_LANES-1:0][1:0]             expInL;
  logic [NUM_LANES-1:0][NUM_PORTS-1:0]   driveL;
  logic [NUM_LANES-1:0][1:0]             expDrvL;

  assign padL[0]     = sdaPad;
  assign padL[1]     = sclPad;
  assign expInL[0]   = sdaExpIn;
  assign expInL[1]   = sclExpIn;
  assign sdaDrive    = driveL[0];
  assign sclDrive    = driveL[1];
  assign sdaExpDrive = expDrvL[0];
  assign sclExpDrive = expDrvL[1];

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    laneStrobe_t laneStr;
    laneStatus_t laneSts;

    hub_lane_ctrl u_ctrl (
      .clk (clk),
      .rstN(rstN),
      .sts (laneSts),
      .str (laneStr)
    );

    hub_lane_dp #(
      .NUM_PORTS  (NUM_PORTS),
      .SYNC_STAGES(SYNC_STAGES),
      .RISE_CYCLES(RISE_CYCLES)
    ) u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .portEn  (portEn),
      .padIn   (padL[l]),
      .expIn   (expInL[l]),
      .strobe  (laneStr),
      .status  (laneSts),
      .driveLow(driveL[l]),
      .expDrive(expDrvL[l])
    );
  end

endmodule

// File: tb/bus_hub_repeater_bench.sv
`timescale 1ns/1ps
module bus_hub_repeater_bench;

  localparam int NP = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic [NP-2:0] enA = 4'b1111, enB = 4'b0011;
  logic [NP-1:0] extSdaA = '0, extSclA = '0, extSdaB = '0, extSclB = '0;
  logic [NP-1:0] slowSdaA = '0;

  logic [NP-1:0] aSdaDrv, aSclDrv, bSdaDrv, bSclDrv;
  logic [1:0]    aSdaExp, aSclExp, bSdaExp, bSclExp;
  logic [1:0]    sdaBus, sclBus;

  function automatic logic [2*NP-1:0] padOf(input logic [NP-1:0] ext,
                                           input logic [NP-1:0] drv,
                                           input logic [NP-1:0] slow);
    logic [2*NP-1:0] r;
    for (int i = 0; i < NP; i++) begin
      r[2*i +: 2] = ext[i] ? 2'b11 : ((drv[i] | slow[i]) ? 2'b01 : 2'b00);
    end
    return r;
  endfunction

  assign sdaBus = ~(aSdaExp | bSdaExp);
  assign sclBus = ~(aSclExp | bSclExp);

  bus_hub_repeater u_bus_hub_repeater (
    .clk(clk), .rstN(rstN), .enIn(enA),
    .sdaPad(padOf(extSdaA, aSdaDrv, slowSdaA)),
    .sclPad(padOf(extSclA, aSclDrv, '0)),
    .sdaExpIn(sdaBus), .sclExpIn(sclBus),
    .sdaDrive(aSdaDrv), .sclDrive(aSclDrv),
    .sdaExpDrive(aSdaExp), .sclExpDrive(aSclExp)
  );

  bus_hub_repeater u_bus_hub_repeater_peer (
    .clk(clk), .rstN(rstN), .enIn(enB),
    .sdaPad(padOf(extSdaB, bSdaDrv, '0)),
    .sclPad(padOf(extSclB, bSclDrv, '0)),
    .sdaExpIn(sdaBus), .sclExpIn(sclBus),
    .sdaDrive(bSdaDrv), .sclDrive(bSclDrv),
    .sdaExpDrive(bSdaExp), .sclExpDrive(bSclExp)
  );

  typedef struct {
    string         tag;
    logic [NP-1:0] aSda, bSda, aScl, bScl;
    logic [1:0]    sdaB, sclB;
  } expItem_t;

  expItem_t expQ[$];
  int checkCount = 0;
  int failCount  = 0;
  bit done = 1'b0;

  // driver side: push the expected picture, monitor compares it
  task automatic expectNow(input string tag,
                           input logic [NP-1:0] aSda, input logic [NP-1:0] bSda,
                           input logic [NP-1:0] aScl, input logic [NP-1:0] bScl,
                           input logic [1:0] sdaB, input logic [1:0] sclB);
    expItem_t it;
    it.tag = tag; it.aSda = aSda; it.bSda = bSda; it.aScl = aScl; it.bScl = bScl;
    it.sdaB = sdaB; it.sclB = sclB;
    expQ.push_back(it);
    @(posedge clk);
  endtask

  initial begin : monitor
    expItem_t it;
    forever begin
      wait (expQ.size() != 0);
      it = expQ.pop_front();
      checkCount++;
      if (aSdaDrv !== it.aSda || bSdaDrv !== it.bSda || aSclDrv !== it.aScl ||
          bSclDrv !== it.bScl || sdaBus !== it.sdaB || sclBus !== it.sclB) begin
        failCount++;
        $display("FAIL %s: actual aSda=%b bSda=%b aScl=%b bScl=%b sdaBus=%b sclBus=%b expected aSda=%b bSda=%b aScl=%b bScl=%b sdaBus=%b sclBus=%b",
                 it.tag, aSdaDrv, bSdaDrv, aSclDrv, bSclDrv, sdaBus, sclBus,
                 it.aSda, it.bSda, it.aScl, it.bScl, it.sdaB, it.sclB);
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectRest(input string tag);
    expectNow(tag, '0, '0, '0, '0, 2'b11, 2'b11);
  endtask

  initial begin : stimulus
    waitCyc(3);
    expectRest("R12 reset state");
    rstN = 1'b1;
    waitCyc(5);

    extSdaA[2] = 1'b1; waitCyc(20);
    expectNow("R2 R3 R8 R11 strong low on hub A port 2",
              5'b11111, 5'b00111, '0, '0, 2'b00, 2'b11);
    extSdaA[2] = 1'b0; waitCyc(40);
    expectRest("R7 R4 release after single source");

    extSdaB[3] = 1'b1; waitCyc(20);
    expectRest("R10 strong low on disabled port ignored");
    extSdaB[3] = 1'b0; waitCyc(10);

    enB = 4'b0000; waitCyc(5);
    extSdaB[0] = 1'b1; waitCyc(20);
    expectNow("R1 port 0 active with all enables low",
              5'b11111, 5'b00001, '0, '0, 2'b00, 2'b11);
    extSdaB[0] = 1'b0; waitCyc(40);
    expectRest("R1 release from port 0");
    enB = 4'b0011; waitCyc(5);

    extSclA[0] = 1'b1; waitCyc(20);
    extSclB[1] = 1'b1; waitCyc(20);
    extSclA[0] = 1'b0; waitCyc(30);
    expectNow("R9 stretch on weakly held port keeps cluster low",
              '0, '0, 5'b11111, 5'b00111, 2'b11, 2'b00);
    extSclB[1] = 1'b0; waitCyc(40);
    expectRest("R7 release after stretch");

    extSdaA[1] = 1'b1; extSdaB[0] = 1'b1; waitCyc(20);
    extSdaA[1] = 1'b0; waitCyc(30);
    expectNow("R5 released source held while level-2 low",
              5'b11111, 5'b00111, '0, '0, 2'b00, 2'b11);
    extSdaB[0] = 1'b0; waitCyc(40);
    expectRest("R7 release after two sources");

    extSdaA[4] = 1'b1; slowSdaA[4] = 1'b1; waitCyc(20);
    extSdaA[4] = 1'b0; waitCyc(60);
    expectNow("R6 level-1 held until timeout while source rises slowly",
              5'b01111, 5'b00111, '0, '0, 2'b10, 2'b11);
    waitCyc(190);
    expectRest("R6 R4 timeout released, weak pad not a source");
    slowSdaA[4] = 1'b0; waitCyc(10);
    expectRest("R4 rest after slow node clears");

    extSdaA[3] = 1'b1; extSclB[2] = 1'b1; waitCyc(20);
    expectNow("R11 both lanes active from different hubs",
              5'b11111, 5'b00111, 5'b11111, 5'b00111, 2'b00, 2'b00);
    extSdaA[3] = 1'b0; waitCyc(40);
    expectNow("R11 data lane releases while clock lane held",
              '0, '0, 5'b11111, 5'b00111, 2'b11, 2'b00);
    extSclB[2] = 1'b0; waitCyc(40);
    expectRest("R7 final rest");

    wait (expQ.size() == 0);
    waitCyc(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule